// File: doc/BRIEF.md
# Banked GPIO Mode Controller

This block owns the configuration and output state of sixteen general-purpose pins. The pins sit in four banks of unequal size, and each bank keeps its own configuration register and its own output-data register. Every pin carries a 4-bit mode field that selects plain input, plain output or one of a few alternate functions.

A single request port carries four kinds of request: a masked mode write, a masked output-data write, a read of pin levels and a read that reports which pins sit in a given mode. Writes are checked for legality before anything changes. A mode write that names a pin not permitted for that mode is refused as a whole. A data write that names any pin not currently in output mode is refused as a whole. A refused request produces a one-cycle error pulse. Pins in output mode enable their pad drivers and present the stored output bit. The pads themselves, the alternate-function peripherals and interrupt logic live outside this block.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset every pin is in mode 0x0 (input), every output-data bit is 0, padOe and padOut are all zero, and errPulse and rdValid are low.
- R2: The banks hold 2, 4, 4 and 6 pins and start at global pins 0, 2, 6 and 10. A pin's mode is the 4-bit field at bit 4 × (index within its bank) of that bank's configuration register. Bank edges must not alias, so a write to pin 5 leaves pin 6 untouched and a write to pin 9 leaves pin 10 untouched.
- R3: Mode codes are 0x0 input, 0x1 interrupt, 0x2 serial input, 0x8 output, 0x9 serial output / timer A, 0xA timer B, and 0x3 to 0x7 reserved. padOe[p] is 1 exactly when pin p is in mode 0x8, and padOut[p] shows pin p's stored output bit.
- R4: Modes 0x0 and 0x8 are legal on every pin. 0x2 is legal only on pins 4 and 5, 0x9 only on pins 0 to 3, and 0xA only on pins 0 and 1. 0x1 and the reserved codes 0x3 to 0x7, 0xB to 0xF are legal on no pin.
- R5: A mode write whose mask holds any pin not legal for the requested mode is refused, and no mode field changes.
- R6: A data write whose mask holds any pin that is not in mode 0x8 is refused, and no output bit changes.
- R7: An accepted write changes only the masked pins. An all-zero mask is accepted and changes nothing.
- R8: A level read (reqKind 2'b10) returns rdValid high in the cycle after the request. rdData[p] equals the stored output bit for a pin in mode 0x8, and padIn[p] for any other pin.
- R9: A mode-match read (reqKind 2'b11) returns rdValid high in the cycle after the request, with rdData[p] = 1 exactly when pin p's mode equals reqMode.
- R10: errPulse is high for exactly the one cycle after a refused request and low after any accepted request. Request kinds are encoded 2'b00 mode write (mode in reqMode) and 2'b01 data write (values in reqData).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 00 mode write, 01 data write, 10 level read, 11 mode-match read |
| reqMask | input | 16 | Pins the request applies to, one bit per global pin |
| reqData | input | 16 | Output values for a data write |
| reqMode | input | 4 | Mode code for a mode write or a mode-match read |
| padIn | input | 16 | Sampled pad levels |
| padOut | output | 16 | Stored output data per pin |
| padOe | output | 16 | Output enable, high for pins in output mode |
| rdValid | output | 1 | Read result valid |
| rdData | output | 16 | Read result |
| errPulse | output | 1 | One-cycle pulse after a refused request |

## Verification
A corrupted mode field shows up at padOe in the cycle after the write, and it shows up in any later mode-match read. A wrong output bit shows directly on padOut at the next edge. A legality check that is too loose lets a field change that should have stayed put. A check that is too strict refuses a legal write. Either fault appears as an errPulse of the wrong value one cycle after the request, and it also appears in the padOe and padOut state that follows. The bench aims at bank boundaries, mixed masks that contain a single illegal pin, and reserved codes, because each of these turns a hidden decode fault into a visible port difference within two cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  parameter int BANK_COUNT = 4;
  parameter int MODE_W     = 4;

  // pins held by each bank; uneven split is part of the register layout
  function automatic int bankSize(input int b);
    case (b)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int bankBase(input int b);
    int acc = 0;
    for (int i = 0; i < b; i++) acc += bankSize(i);
    return acc;
  endfunction

  localparam int PIN_COUNT = bankBase(BANK_COUNT);

  localparam logic [MODE_W-1:0] MODE_IN     = 4'h0;
  localparam logic [MODE_W-1:0] MODE_IRQ    = 4'h1;
  localparam logic [MODE_W-1:0] MODE_SER_IN = 4'h2;
  localparam logic [MODE_W-1:0] MODE_OUT    = 4'h8;
  localparam logic [MODE_W-1:0] MODE_ALT_A  = 4'h9;
  localparam logic [MODE_W-1:0] MODE_ALT_B  = 4'hA;

  typedef enum logic [1:0] {
    REQ_SET_MODE  = 2'b00,
    REQ_SET_DATA  = 2'b01,
    REQ_GET_LEVEL = 2'b10,
    REQ_GET_MATCH = 2'b11
  } req_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic writeMode;
    logic writeData;
    logic readLevel;
    logic readMatch;
    logic reject;
  } ctrl_stb_t;

  // pins on which a mode code may be placed
  function automatic logic [PIN_COUNT-1:0] legalPins(input logic [MODE_W-1:0] m);
    logic [PIN_COUNT-1:0] r;
    r = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      case (m)
        MODE_IN, MODE_OUT: r[p] = 1'b1;
        MODE_SER_IN:       r[p] = (p == 4) || (p == 5);
        MODE_ALT_A:        r[p] = (p <= 3);
        MODE_ALT_B:        r[p] = (p <= 1);
        default:           r[p] = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [PIN_COUNT-1:0]  reqMask,
  input  logic [MODE_W-1:0]     reqMode,
  input  logic [PIN_COUNT-1:0]  outMask,
  output ctrl_stb_t             stb,
  output logic                  errPulse
);

  req_kind_e kind;
  logic      modeBad;
  logic      dataBad;

  assign kind    = req_kind_e'(reqKind);
  assign modeBad = |(reqMask & ~legalPins(reqMode));
  assign dataBad = |(reqMask & ~outMask);

  always_comb begin
    stb = '0;
    if (reqValid) begin
      case (kind)
        REQ_SET_MODE: begin
          stb.writeMode = !modeBad;
          stb.reject    = modeBad;
        end
        REQ_SET_DATA: begin
          stb.writeData = !dataBad;
          stb.reject    = dataBad;
        end
        REQ_GET_LEVEL: stb.readLevel = 1'b1;
        default:       stb.readMatch = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= stb.reject;
  end

  // R4: an accepted mode write never names a pin outside the legal set
  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeMode |-> ((reqMask & ~legalPins(reqMode)) == '0));

  // R6: an accepted data write names only pins the datapath reports as outputs
  assert_data_outputs_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeData |-> ((reqMask & ~outMask) == '0));

  // R10: a refusal is followed by the error pulse
  assert_err_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> errPulse);

  // R10: an accepted request is followed by a quiet error line
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeMode || stb.writeData) |=> !errPulse);

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_stb_t             stb,
  input  logic [PIN_COUNT-1:0]  reqMask,
  input  logic [PIN_COUNT-1:0]  reqData,
  input  logic [MODE_W-1:0]     reqMode,
  input  logic [PIN_COUNT-1:0]  padIn,
  output logic [PIN_COUNT-1:0]  outMask,
  output logic [PIN_COUNT-1:0]  padOut,
  output logic                  rdValid,
  output logic [PIN_COUNT-1:0]  rdData
);

  logic [PIN_COUNT-1:0][MODE_W-1:0] pinMode;
  logic [PIN_COUNT-1:0]             pinData;
  logic [PIN_COUNT-1:0]             levelVec;
  logic [PIN_COUNT-1:0]             matchVec;

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    localparam int SZ   = bankSize(b);
    localparam int BASE = bankBase(b);

    logic [MODE_W*SZ-1:0] cfgReg;
    logic [SZ-1:0]        datReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg <= '0;
        datReg <= '0;
      end else begin
        for (int i = 0; i < SZ; i++) begin
          if (stb.writeMode && reqMask[BASE+i])
            cfgReg[MODE_W*i +: MODE_W] <= reqMode;
          if (stb.writeData && reqMask[BASE+i])
            datReg[i] <= reqData[BASE+i];
        end
      end
    end

    for (genvar i = 0; i < SZ; i++) begin : g_pin
      assign pinMode[BASE+i] = cfgReg[MODE_W*i +: MODE_W];
      assign pinData[BASE+i] = datReg[i];
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_view
    assign outMask[p]  = (pinMode[p] == MODE_OUT);
    assign levelVec[p] = outMask[p] ? pinData[p] : padIn[p];
    assign matchVec[p] = (pinMode[p] == reqMode);

    // R5: mode fields move only under an accepted mode write
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !stb.writeMode |=> $stable(pinMode[p]));

    // R7: a masked pin takes the requested code
    assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.writeMode && reqMask[p]) |=> (pinMode[p] == $past(reqMode)));

    // R6: output bits move only under an accepted data write
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !stb.writeData |=> $stable(pinData[p]));
  end

  assign padOut = pinData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.readLevel || stb.readMatch;
      if (stb.readLevel)      rdData <= levelVec;
      else if (stb.readMatch) rdData <= matchVec;
    end
  end

  // R8/R9: every read request is answered on the next cycle
  assert_read_answer_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readLevel || stb.readMatch) |=> rdValid);

endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import gpio_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic [PIN_COUNT-1:0]  reqMask,
  input  logic [PIN_COUNT-1:0]  reqData,
  input  logic [MODE_W-1:0]     reqMode,
  input  logic [PIN_COUNT-1:0]  padIn,
  output logic [PIN_COUNT-1:0]  padOut,
  output logic [PIN_COUNT-1:0]  padOe,
  output logic                  rdValid,
  output logic [PIN_COUNT-1:0]  rdData,
  output logic                  errPulse
);

  ctrl_stb_t            stb;
  logic [PIN_COUNT-1:0] outMask;

  gpio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqMask  (reqMask),
    .reqMode  (reqMode),
    .outMask  (outMask),
    .stb      (stb),
    .errPulse (errPulse)
  );

  gpio_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqMask (reqMask),
    .reqData (reqData),
    .reqMode (reqMode),
    .padIn   (padIn),
    .outMask (outMask),
    .padOut  (padOut),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign padOe = outMask;

endmodule

// File: tb/banked_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [15:0] reqMask = '0;
  logic [15:0] reqData = '0;
  logic [3:0]  reqMode = '0;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOe, rdData;
  logic        rdValid, errPulse;

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] value;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [3:0]  mMode [16];
  logic [15:0] mData;

  always #2 clk = ~clk;

  banked_gpio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqMask(reqMask), .reqData(reqData), .reqMode(reqMode), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .rdValid(rdValid), .rdData(rdData),
    .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] benchLegal(input logic [3:0] m);
    case (m)
      4'h0, 4'h8: return 16'hFFFF;
      4'h2:       return 16'h0030;
      4'h9:       return 16'h000F;
      4'hA:       return 16'h0003;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] benchOe();
    logic [15:0] r;
    for (int p = 0; p < 16; p++) r[p] = (mMode[p] == 4'h8);
    return r;
  endfunction

  // driver: called at a falling edge, returns at a falling edge
  task automatic req(input logic [1:0] k, input logic [15:0] m,
                     input logic [15:0] v, input logic [3:0] md,
                     input string tag);
    bit expErr;
    exp_t e;
    expErr = 1'b0;
    case (k)
      2'b00: begin
        expErr = |(m & ~benchLegal(md));
        if (!expErr)
          for (int p = 0; p < 16; p++) if (m[p]) mMode[p] = md;
      end
      2'b01: begin
        expErr = |(m & ~benchOe());
        if (!expErr) mData = (mData & ~m) | (v & m);
      end
      2'b10: begin
        for (int p = 0; p < 16; p++)
          e.value[p] = (mMode[p] == 4'h8) ? mData[p] : padIn[p];
        e.tag = tag;
        expQ.push_back(e);
      end
      default: begin
        for (int p = 0; p < 16; p++) e.value[p] = (mMode[p] == md);
        e.tag = tag;
        expQ.push_back(e);
      end
    endcase
    reqValid = 1'b1; reqKind = k; reqMask = m; reqData = v; reqMode = md;
    @(negedge clk);
    reqValid = 1'b0;
    check(errPulse == expErr, {tag, " R10 err"}, {15'd0, errPulse}, {15'd0, expErr});
    check(padOe == benchOe(), {tag, " R3 padOe"}, padOe, benchOe());
    check(padOut == mData, {tag, " R7 padOut"}, padOut, mData);
    @(negedge clk);
    check(errPulse == 1'b0, {tag, " R10 single pulse"}, {15'd0, errPulse}, 16'd0);
  endtask

  // monitor: compare read results against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected rdValid", rdData, 16'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rdData == e.value, e.tag, rdData, e.value);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    finish_run();
  end

  initial begin
    for (int p = 0; p < 16; p++) mMode[p] = 4'h0;
    mData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(padOe == 16'h0, "R1 padOe", padOe, 16'h0);
    check(padOut == 16'h0, "R1 padOut", padOut, 16'h0);
    check(errPulse == 1'b0, "R1 errPulse", {15'd0, errPulse}, 16'h0);
    check(rdValid == 1'b0, "R1 rdValid", {15'd0, rdValid}, 16'h0);
    req(2'b11, 16'h0, 16'h0, 4'h0, "R1 all pins input R9");

    // R2 bank edges: outputs on 0,1,5,6,9,10,15
    req(2'b00, 16'h8663, 16'h0, 4'h8, "R2 output on bank edges");
    req(2'b11, 16'h0, 16'h0, 4'h8, "R2 match output R9");
    req(2'b11, 16'h0, 16'h0, 4'h0, "R2 match input R9");

    // R3 / R7 drive data
    req(2'b01, 16'h8663, 16'hFFFF, 4'h0, "R3 drive outputs high");
    req(2'b01, 16'h0021, 16'h0000, 4'h0, "R7 partial clear");
    req(2'b01, 16'h0000, 16'hFFFF, 4'h0, "R7 empty mask");

    // R6 data write touching an input pin
    req(2'b01, 16'h0007, 16'h0000, 4'h0, "R6 refuse non-output pin");
    req(2'b01, 16'h0000, 16'h0000, 4'h0, "R6 idle");

    // R4 / R5 legality
    req(2'b00, 16'h0030, 16'h0, 4'h2, "R4 serial input on 4,5");
    req(2'b00, 16'h0008, 16'h0, 4'h2, "R5 serial input on 3 refused");
    req(2'b00, 16'h0007, 16'h0, 4'hA, "R5 timer B mixed mask refused");
    req(2'b11, 16'h0, 16'h0, 4'h8, "R5 modes unchanged R9");
    req(2'b00, 16'h0003, 16'h0, 4'hA, "R4 timer B on 0,1");
    req(2'b00, 16'h000C, 16'h0, 4'h9, "R4 mode 9 on 2,3");
    req(2'b00, 16'h0010, 16'h0, 4'h9, "R5 mode 9 on 4 refused");
    req(2'b00, 16'h0001, 16'h0, 4'h1, "R4 interrupt refused");
    req(2'b00, 16'h0400, 16'h0, 4'h5, "R4 reserved refused");
    req(2'b00, 16'h0000, 16'h0, 4'h5, "R7 empty mask reserved accepted");
    req(2'b11, 16'h0, 16'h0, 4'hA, "R9 match timer B");
    req(2'b11, 16'h0, 16'h0, 4'h9, "R9 match mode 9");
    req(2'b11, 16'h0, 16'h0, 4'h5, "R9 match reserved");

    // R8 level reads
    padIn = 16'hA5C3;
    req(2'b10, 16'h0, 16'h0, 4'h0, "R8 level mix");
    padIn = 16'h5A3C;
    req(2'b01, 16'h8640, 16'h0640, 4'h0, "R7 write remaining outputs");
    req(2'b10, 16'h0, 16'h0, 4'h0, "R8 level second pattern");
    req(2'b00, 16'h0400, 16'h0, 4'h0, "R2 pin 10 back to input");
    req(2'b10, 16'h0, 16'h0, 4'h0, "R8 level after mode change");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 reads outstanding", 16'(expQ.size()), 16'h0);
    finish_run();
  end

endmodule